// File: doc/BRIEF.md
# Division Feedback Posterior Estimator

This block estimates a conditional probability P(A|B) from two stochastic bit streams, one for the result node A and one for the condition node B, without a divider. An internal probabilistic bit, built from an LFSR compared against an 8-bit probability register, fires with an adjustable probability. Each clock cycle while running is one sample. Over each window of 128 samples, the block counts two things. The first is the number of cycles where A and B are both true. The second is the number of cycles where B and the internal bit are both true. At the end of the window the probability register moves by the count difference times a learning rate. That rate decays exponentially from one window to the next.

After 20 windows the register holds the estimate. The value r on `prob_o` stands for r/256. The register settles where P(B) times its value equals P(A and B), which is the quotient asked for. Each input stream can be inverted, so the block can condition on a node being false, or ask about one being false. Generating the node streams is the job of the surrounding logic.

Top module: `posterior_divfb`

## Requirements
- R1: After reset, `prob_o` is 128 and `done_o` is 0.
- R2: A `start` high at a clock edge while idle begins a run. That edge sets the probability register to 128 and the LFSR to 0xA5. A `start` seen during a run has no effect on the result.
- R3: Every clock edge of a run is one sample. The internal bit is 1 when the LFSR value, read as unsigned, is below the probability register. The numerator count adds effective A AND effective B. The feedback count adds effective B AND the internal bit. After each sample the LFSR shifts left and takes into bit 0 the XOR of its bits 7, 5, 4 and 3.
- R4: A window is 128 samples. At the window's last sample, the register gains floor((num − fb) × eta_n / 16384). Here num and fb include that last sample, n is the window index 0..19, and eta_n = round(32768 × exp(−0.15 × n)). Between window ends `prob_o` does not change.
- R5: The updated probability is clamped to 0..255 and never wraps.
- R6: Effective A is `a_bit` XOR `inv_a`, and effective B is `b_bit` XOR `inv_b`.
- R7: A run is exactly 20 windows. `done_o` is high for one cycle, which follows the edge that takes the 2560th sample. At that point the run ends.
- R8: After a run, `prob_o` holds the final estimate unchanged until the next accepted `start`.
- R9: If effective B is never true, both counts stay zero and the result is exactly 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| a_bit | input | 1 | Result-node sample stream |
| b_bit | input | 1 | Condition-node sample stream |
| inv_a | input | 1 | Invert the result stream |
| inv_b | input | 1 | Invert the condition stream |
| prob_o | output | 8 | Probability estimate, value/256 |
| done_o | output | 1 | One-cycle pulse at end of run |

## Verification
A wrong count, a wrong LFSR step or a wrong internal-bit compare does not show at once. It shows at the next window end, at most 128 cycles later, as a `prob_o` step that differs from an independent model of the same arithmetic. A bad learning-rate entry or a bad clamp shows in the same way, at the window that uses it. A miscounted iteration index shows as `done_o` arriving at the wrong cycle. Once the run is over, a register that drifts shows as `prob_o` changing while idle.

// File: rtl/posterior_divfb.sv
module posterior_divfb #(
  parameter int PW = 8,
  parameter int WIN = 128,
  parameter int ITERS = 20,
  parameter logic [PW-1:0] SEED = 8'hA5,
  parameter logic [PW-1:0] TAPS = 8'hB8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          a_bit,
  input  logic          b_bit,
  input  logic          inv_a,
  input  logic          inv_b,
  output logic [PW-1:0] prob_o,
  output logic          done_o
);
  localparam int CW = $clog2(WIN + 1);
  localparam int IW = $clog2(ITERS);
  localparam int SH = 15 + $clog2(WIN) - PW;
  localparam int XW = CW + 18;
  localparam logic [PW-1:0] HALF = {1'b1, {(PW-1){1'b0}}};
  localparam logic signed [XW-1:0] PMAX_S = XW'((1 << PW) - 1);

  logic          busy;
  logic [PW-1:0] p, lfsr;
  logic [CW-1:0] win_cnt, num, fb;
  logic [IW-1:0] it;

  function automatic logic [15:0] eta_of(input logic [IW-1:0] n);
    case (int'(n))
      0: eta_of = 16'd32768;  1: eta_of = 16'd28204;  2: eta_of = 16'd24275;
      3: eta_of = 16'd20894;  4: eta_of = 16'd17983;  5: eta_of = 16'd15479;
      6: eta_of = 16'd13322;  7: eta_of = 16'd11467;  8: eta_of = 16'd9870;
      9: eta_of = 16'd8495;   10: eta_of = 16'd7312;  11: eta_of = 16'd6293;
      12: eta_of = 16'd5417;  13: eta_of = 16'd4662;  14: eta_of = 16'd4013;
      15: eta_of = 16'd3454;  16: eta_of = 16'd2973;  17: eta_of = 16'd2559;
      18: eta_of = 16'd2202;  19: eta_of = 16'd1895;
      default: eta_of = 16'd0;
    endcase
  endfunction

  wire ae   = a_bit ^ inv_a;
  wire be   = b_bit ^ inv_b;
  wire peri = lfsr < p;
  wire last_smp = busy && (win_cnt == CW'(WIN - 1));
  wire last_it  = (it == IW'(ITERS - 1));

  wire [CW-1:0] num_nx = num + {{(CW-1){1'b0}}, ae & be};
  wire [CW-1:0] fb_nx  = fb + {{(CW-1){1'b0}}, be & peri};

  logic signed [CW:0]    diff;
  logic signed [XW-1:0]  prod, sum;
  logic [PW-1:0]         p_new;

  always_comb begin
    diff = $signed({1'b0, num_nx}) - $signed({1'b0, fb_nx});
    prod = diff * $signed({1'b0, eta_of(it)});
    sum  = $signed({{(XW-PW){1'b0}}, p}) + (prod >>> SH);
    if (sum < 0)           p_new = '0;
    else if (sum > PMAX_S) p_new = '1;
    else                   p_new = sum[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; p <= HALF; lfsr <= SEED;
      win_cnt <= '0; num <= '0; fb <= '0; it <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; p <= HALF; lfsr <= SEED;
          win_cnt <= '0; num <= '0; fb <= '0; it <= '0;
        end
      end else begin
        lfsr <= {lfsr[PW-2:0], ^(lfsr & TAPS)};
        if (last_smp) begin
          p <= p_new;
          win_cnt <= '0; num <= '0; fb <= '0;
          it <= it + IW'(1);
          if (last_it) begin
            busy <= 1'b0;
            done_o <= 1'b1;
          end
        end else begin
          win_cnt <= win_cnt + CW'(1);
          num <= num_nx;
          fb <= fb_nx;
        end
      end
    end
  end

  assign prob_o = p;

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && prob_o == HALF));
  // R4
  mid_window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_smp) |=> $stable(prob_o));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  done_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy && $past(busy)));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(prob_o));
endmodule

// File: tb/sim_posterior_divfb.sv
module sim_posterior_divfb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic a_bit = 1'b0, b_bit = 1'b0, inv_a = 1'b0, inv_b = 1'b0;
  logic [7:0] prob_o;
  logic done_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  posterior_divfb u0 (.clk(clk), .rst_n(rst_n), .start(start), .a_bit(a_bit),
    .b_bit(b_bit), .inv_a(inv_a), .inv_b(inv_b), .prob_o(prob_o), .done_o(done_o));

  // fields: A threshold of 256, B true-slots of 4, inv_a, inv_b, ideal quotient x256
  localparam int VEC [6][5] = '{
    '{64, 4, 0, 0, 64}, '{192, 4, 0, 0, 192}, '{128, 2, 0, 0, 128},
    '{64, 1, 0, 1, 64}, '{64, 4, 1, 0, 192}, '{224, 2, 1, 1, 32}};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eta_tab(input int n);
    return $rtoi(32768.0 * $exp(-0.15 * n) + 0.5);
  endfunction

  task automatic run_case(input int thr, input int kb, input bit ia, input bit ib,
                          input int poke, output int mres);
    int mp, num, fb, k, it, d;
    logic [7:0] ml;
    logic [15:0] r;
    bit av, bv, ae, be, pe;
    mp = 128; ml = 8'hA5; num = 0; fb = 0; k = 0; it = 0; r = 16'hACE1;
    @(negedge clk);
    start = 1'b1; inv_a = ia; inv_b = ib; a_bit = 1'b0; b_bit = 1'b0;
    for (int s = 0; s < 2560; s++) begin
      @(negedge clk);
      start = (s == poke);
      av = (int'(r[7:0]) < thr);
      bv = ((s % 4) < kb);
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      a_bit = av; b_bit = bv;
      ae = av ^ ia; be = bv ^ ib; pe = (int'(ml) < mp);
      num += int'(ae & be);
      fb += int'(be & pe);
      ml = {ml[6:0], ml[7] ^ ml[5] ^ ml[4] ^ ml[3]};
      k++;
      if (k == 128) begin
        d = ((num - fb) * eta_tab(it)) >>> 14;
        mp = mp + d;
        if (mp < 0) mp = 0;
        if (mp > 255) mp = 255;
        num = 0; fb = 0; k = 0; it++;
      end
    end
    @(negedge clk);
    start = 1'b0;
    check(done_o === 1'b1, "R7 done after 2560 samples", int'(done_o), 1);
    check(prob_o === 8'(mp), "R4 final estimate", int'(prob_o), mp);
    mres = mp;
    @(negedge clk);
    check(done_o === 1'b0, "R7 done one cycle", int'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int res, df;
    repeat (3) @(negedge clk);
    check(prob_o === 8'd128, "R1 reset prob", int'(prob_o), 128);
    check(done_o === 1'b0, "R1 reset done", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      run_case(VEC[v][0], VEC[v][1], VEC[v][2] != 0, VEC[v][3] != 0, -1, res);
      df = res - VEC[v][4];
      if (df < 0) df = -df;
      check(df <= 48, (VEC[v][2] != 0 || VEC[v][3] != 0) ? "R6 inverted quotient" : "R3 quotient",
            res, VEC[v][4]);
    end

    // R2 start during a run is ignored
    run_case(64, 4, 1'b0, 1'b0, 1000, res);

    // R8 result held while idle with toggling streams
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      a_bit = ~a_bit; b_bit = ~b_bit;
      check(prob_o === 8'(res), "R8 held result", int'(prob_o), res);
    end

    // R5 upper clamp: A and B always true
    run_case(256, 4, 1'b0, 1'b0, -1, res);
    check(prob_o === 8'd255, "R5 upper clamp", int'(prob_o), 255);

    // R5 lower bound: A never true
    run_case(0, 4, 1'b0, 1'b0, -1, res);
    check(int'(prob_o) <= 8, "R5 lower clamp", int'(prob_o), 0);

    // R9 B never true
    run_case(128, 0, 1'b0, 1'b0, -1, res);
    check(prob_o === 8'd128, "R9 no evidence", int'(prob_o), 128);

    // R2 restart reloads 128 on the edge after start
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(prob_o === 8'd128, "R2 reload", int'(prob_o), 128);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule